// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block stores received frames in a circular region of local byte memory that is organised in 256-byte pages. A frame arrives as a byte stream with first-byte and last-byte markers. When its first byte arrives, the block checks that the controller is running and that the ring has enough free room ahead of the host's read boundary. If either check fails, the whole frame is discarded. An accepted frame is written one byte per clock. The data starts four bytes into the current page and wraps from the stop address back to the start address. Frames shorter than the minimum length are padded with zero bytes.

Once the data is stored, the block fills the four reserved bytes at the front of the frame with a small header: status, next page, and the stored length as two bytes. It then pulses a completion strobe that carries the page where the following frame will begin, together with the receive status byte. The register that holds the current page lives outside the block: the host or the surrounding controller loads it from the completion output. The ring bounds are page numbers. Every address in the ring is a page number times 256.

Top module: `rxr_ring_writer`

## Requirements
- R1: While `rx_stopped` is high when a frame's first byte arrives, that frame causes no memory write and no completion pulse.
- R2: Let idx = `cur_pg`*256, bnd = `bound_pg`*256 and ring = (`stop_pg`-`start_pg`)*256. Free room is bnd-idx when idx<bnd, and ring-(idx-bnd) otherwise. A frame is dropped (no write, no pulse) when free room is below 1518 bytes.
- R3: Data byte k of an accepted frame is written to address `cur_pg`*256+4+k. An address that would equal `stop_pg`*256 is replaced by `start_pg`*256.
- R4: A frame of fewer than 60 bytes is extended with zero bytes to exactly 60 stored bytes, at the following ring addresses.
- R5: After the data, four header bytes go to `cur_pg`*256+0..3 in this order: status, next page, stored length low byte, stored length high byte. The stored length is the padded data length plus 4.
- R6: The next page is (idx + ceil((stored length+4)/256)*256)/256. If that address is at or above `stop_pg`*256, (`stop_pg`-`start_pg`)*256 is subtracted first.
- R7: The status byte is 0x01, with bit 0x20 also set when `rx_grp` was high with the first byte (group or broadcast destination).
- R8: `rx_done` is high for exactly one cycle, in the same cycle that the last header byte appears on the memory port. `new_pg` and `rx_status` are valid in that cycle.
- R9: At most one memory byte is written per clock. An accepted frame of padded length L produces exactly L+4 writes: data first, then padding, then header. `mem_we` and `rx_done` are low after reset.
- R10: Bytes of a dropped frame, up to and including its last byte, have no effect. The next first byte is judged afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_grp | input | 1 | Destination is group or broadcast; sampled with the first byte |
| rx_stopped | input | 1 | Controller stopped; new frames are refused |
| start_pg | input | 8 | First page of the ring |
| stop_pg | input | 8 | Page one past the end of the ring |
| bound_pg | input | 8 | Host read boundary page |
| cur_pg | input | 8 | Page where the next frame is stored |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| rx_done | output | 1 | One-cycle frame-stored pulse |
| new_pg | output | 8 | Next current page, valid with rx_done |
| rx_status | output | 8 | Receive status byte, valid with rx_done |

## Verification
The frame-length sweep covers 1, 59, 60 and 61 bytes, as well as lengths that land just under and just over a page boundary. It separates padding errors from off-by-one errors in the stored length and in the page rounding of the next pointer. The same lengths are repeated from the last page of the ring, where data crossing the stop address shows whether the wrap is applied and where. A sweep of the boundary page over the whole ring, from two current pages, places the accept/drop edge at exactly six pages of room, on both sides of the index/boundary comparison. Stopped and dropped frames, each followed by a good frame, show that refused bytes leave no trace.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_DATA = 3'd1,
        S_PAD  = 3'd2,
        S_HDR  = 3'd3,
        S_DROP = 3'd4
    } wr_state_e;

    localparam logic [7:0] STAT_OK  = 8'h01;
    localparam logic [7:0] STAT_GRP = 8'h20;

    localparam int unsigned HDR_BYTES = 4;

endpackage

// File: rtl/rxr_space_chk.sv
module rxr_space_chk #(
    parameter int unsigned PAGE_W     = 8,
    parameter int unsigned NEED_BYTES = 1518
) (
    input  logic [PAGE_W-1:0] cur_pg,
    input  logic [PAGE_W-1:0] bound_pg,
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    output logic              room_ok
);
    localparam int unsigned AW = PAGE_W + 8;
    localparam int unsigned SW = AW + 2;

    logic signed [SW-1:0] idx_s;
    logic signed [SW-1:0] bnd_s;
    logic signed [SW-1:0] ring_s;
    logic signed [SW-1:0] avail_s;

    always_comb begin
        idx_s  = $signed({2'b00, cur_pg, 8'h00});
        bnd_s  = $signed({2'b00, bound_pg, 8'h00});
        ring_s = $signed({2'b00, stop_pg, 8'h00}) - $signed({2'b00, start_pg, 8'h00});
        if (idx_s < bnd_s) begin
            avail_s = bnd_s - idx_s;
        end else begin
            avail_s = ring_s - (idx_s - bnd_s);
        end
        room_ok = (avail_s >= $signed(SW'(NEED_BYTES)));
    end

endmodule

// File: rtl/rxr_next_calc.sv
module rxr_next_calc #(
    parameter int unsigned PAGE_W = 8,
    parameter int unsigned LEN_W  = 12
) (
    input  logic [PAGE_W-1:0] base_pg,
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    input  logic [LEN_W-1:0]  stored_len,
    output logic [PAGE_W-1:0] next_pg
);
    localparam int unsigned SUMW = LEN_W + 1;
    localparam int unsigned NW   = PAGE_W + LEN_W;

    logic [SUMW-1:0] span_sum;
    logic [NW-1:0]   raw_pg;

    always_comb begin
        // room for header pointer term, rounded up to whole pages
        span_sum = {1'b0, stored_len} + SUMW'(rxr_pkg::HDR_BYTES + 255);
        raw_pg   = NW'(base_pg) + NW'(span_sum[SUMW-1:8]);
        if (raw_pg >= NW'(stop_pg)) begin
            raw_pg = raw_pg - (NW'(stop_pg) - NW'(start_pg));
        end
        next_pg = raw_pg[PAGE_W-1:0];
    end

endmodule

// File: rtl/rxr_addr_step.sv
module rxr_addr_step #(
    parameter int unsigned PAGE_W = 8
) (
    input  logic [PAGE_W+7:0] cur_addr,
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    output logic [PAGE_W+7:0] nxt_addr
);
    localparam int unsigned AW = PAGE_W + 8;

    logic [AW-1:0] inc_addr;

    always_comb begin
        inc_addr = cur_addr + AW'(1);
        if (inc_addr == {stop_pg, 8'h00}) begin
            nxt_addr = {start_pg, 8'h00};
        end else begin
            nxt_addr = inc_addr;
        end
    end

endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int unsigned PAGE_W     = 8,
    parameter int unsigned LEN_W      = 12,
    parameter int unsigned MIN_LEN    = 60,
    parameter int unsigned NEED_BYTES = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_grp,
    input  logic              rx_stopped,
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    input  logic [PAGE_W-1:0] bound_pg,
    input  logic [PAGE_W-1:0] cur_pg,
    output logic              mem_we,
    output logic [PAGE_W+7:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              rx_done,
    output logic [PAGE_W-1:0] new_pg,
    output logic [7:0]        rx_status
);
    localparam int unsigned AW = PAGE_W + 8;

    typedef struct packed {
        wr_state_e         st;
        logic [AW-1:0]     wa;
        logic [PAGE_W-1:0] base_pg;
        logic [PAGE_W-1:0] lo_pg;
        logic [PAGE_W-1:0] hi_pg;
        logic [LEN_W-1:0]  cnt;
        logic [1:0]        hix;
        logic              we;
        logic [AW-1:0]     addr;
        logic [7:0]        wdata;
        logic              done;
        logic [PAGE_W-1:0] npg;
        logic [7:0]        stat;
    } wr_regs_t;

    wr_regs_t r_d;
    wr_regs_t r_q;

    logic              room_ok;
    logic [AW-1:0]     wa_step;
    logic [LEN_W-1:0]  stored_len;
    logic [PAGE_W-1:0] calc_pg;
    logic [LEN_W-1:0]  cnt_inc;

    rxr_space_chk #(.PAGE_W(PAGE_W), .NEED_BYTES(NEED_BYTES)) u_space (
        .cur_pg   (cur_pg),
        .bound_pg (bound_pg),
        .start_pg (start_pg),
        .stop_pg  (stop_pg),
        .room_ok  (room_ok)
    );

    rxr_addr_step #(.PAGE_W(PAGE_W)) u_step (
        .cur_addr (r_q.wa),
        .start_pg (r_q.lo_pg),
        .stop_pg  (r_q.hi_pg),
        .nxt_addr (wa_step)
    );

    assign stored_len = r_q.cnt + LEN_W'(HDR_BYTES);
    assign cnt_inc    = r_q.cnt + LEN_W'(1);

    rxr_next_calc #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_next (
        .base_pg    (r_q.base_pg),
        .start_pg   (r_q.lo_pg),
        .stop_pg    (r_q.hi_pg),
        .stored_len (stored_len),
        .next_pg    (calc_pg)
    );

    always_comb begin
        r_d      = r_q;
        r_d.we   = 1'b0;
        r_d.done = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (rx_valid && rx_sof) begin
                    if (rx_stopped || !room_ok) begin
                        r_d.st = rx_eof ? S_IDLE : S_DROP;
                    end else begin
                        r_d.base_pg = cur_pg;
                        r_d.lo_pg   = start_pg;
                        r_d.hi_pg   = stop_pg;
                        r_d.stat    = STAT_OK | (rx_grp ? STAT_GRP : 8'h00);
                        r_d.we      = 1'b1;
                        r_d.addr    = {cur_pg, 8'h00} + AW'(HDR_BYTES);
                        r_d.wdata   = rx_data;
                        r_d.wa      = {cur_pg, 8'h00} + AW'(HDR_BYTES + 1);
                        r_d.cnt     = LEN_W'(1);
                        r_d.hix     = 2'd0;
                        if (!rx_eof) begin
                            r_d.st = S_DATA;
                        end else if (MIN_LEN > 1) begin
                            r_d.st = S_PAD;
                        end else begin
                            r_d.st = S_HDR;
                        end
                    end
                end
            end
            S_DATA: begin
                if (rx_valid) begin
                    r_d.we    = 1'b1;
                    r_d.addr  = r_q.wa;
                    r_d.wdata = rx_data;
                    r_d.wa    = wa_step;
                    r_d.cnt   = cnt_inc;
                    if (rx_eof) begin
                        r_d.st = (cnt_inc < LEN_W'(MIN_LEN)) ? S_PAD : S_HDR;
                    end
                end
            end
            S_PAD: begin
                r_d.we    = 1'b1;
                r_d.addr  = r_q.wa;
                r_d.wdata = 8'h00;
                r_d.wa    = wa_step;
                r_d.cnt   = cnt_inc;
                if (cnt_inc >= LEN_W'(MIN_LEN)) begin
                    r_d.st = S_HDR;
                end
            end
            S_HDR: begin
                r_d.we   = 1'b1;
                r_d.addr = {r_q.base_pg, 6'd0, r_q.hix};
                unique case (r_q.hix)
                    2'd0:    r_d.wdata = r_q.stat;
                    2'd1:    r_d.wdata = 8'(calc_pg);
                    2'd2:    r_d.wdata = stored_len[7:0];
                    default: r_d.wdata = 8'(stored_len >> 8);
                endcase
                r_d.hix = r_q.hix + 2'd1;
                if (r_q.hix == 2'd3) begin
                    r_d.done = 1'b1;
                    r_d.npg  = calc_pg;
                    r_d.st   = S_IDLE;
                end
            end
            S_DROP: begin
                if (rx_valid && rx_eof) begin
                    r_d.st = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_we    = r_q.we;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign rx_done   = r_q.done;
    assign new_pg    = r_q.npg;
    assign rx_status = r_q.stat;

    // R1: a refused first byte writes nothing in the next cycle
    a_r1_stopped_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE && rx_valid && rx_sof && rx_stopped) |=> !mem_we);

    // R3: a write never targets the stop address
    a_r3_no_stop_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr != {r_q.hi_pg, 8'h00}));

    // R6: next page stays inside the ring
    a_r6_page_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> (new_pg >= r_q.lo_pg && new_pg < r_q.hi_pg));

    // R7: status always carries the ok bit
    a_r7_status_ok: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> rx_status[0]);

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R8: completion coincides with the last header byte write
    a_r8_done_with_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> (mem_we && mem_addr == {r_q.base_pg, 8'h03}));

    // R10: a dropping frame causes no write
    a_r10_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_DROP) |=> !mem_we);

endmodule

// File: tb/rxr_ring_writer_tb_top.sv
module rxr_ring_writer_tb_top;

    localparam int RING_LO = 'h40;
    localparam int RING_HI = 'h4C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_sof = 1'b0;
    logic       rx_eof = 1'b0;
    logic       rx_grp = 1'b0;
    logic       rx_stopped = 1'b0;
    logic [7:0] start_pg = 8'(RING_LO);
    logic [7:0] stop_pg = 8'(RING_HI);
    logic [7:0] bound_pg = 8'h40;
    logic [7:0] cur_pg = 8'h40;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        rx_done;
    logic [7:0]  new_pg;
    logic [7:0]  rx_status;

    int total = 0;
    int bad = 0;
    int rec_n = 0;
    int done_cnt = 0;
    int done_at = 0;
    int rec_addr [0:511];
    int rec_data [0:511];
    int last_pg = 0;
    int last_stat = 0;

    always #4 clk = ~clk;

    rxr_ring_writer dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_grp(rx_grp), .rx_stopped(rx_stopped),
        .start_pg(start_pg), .stop_pg(stop_pg), .bound_pg(bound_pg), .cur_pg(cur_pg),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rx_done(rx_done), .new_pg(new_pg), .rx_status(rx_status)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (rec_n < 512) begin
                    rec_addr[rec_n] = int'(mem_addr);
                    rec_data[rec_n] = int'(mem_wdata);
                end
                rec_n = rec_n + 1;
            end
            if (rx_done) begin
                done_cnt  = done_cnt + 1;
                done_at   = rec_n;
                last_pg   = int'(new_pg);
                last_stat = int'(rx_status);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int fbyte(input int i, input int seed);
        return (i * 7 + seed) & 255;
    endfunction

    task automatic run_frame(input int n, input bit grp, input int cur, input int bnd,
                             input bit stopped, input int seed);
        int idx, bn, ring, room, plen, slen, nxt, base, wrong, a, d;
        bit accept;
        cur_pg = 8'(cur);
        bound_pg = 8'(bnd);
        rx_stopped = stopped;
        @(negedge clk);
        rec_n = 0;
        done_cnt = 0;
        done_at = 0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_sof = (i == 0);
            rx_eof = (i == n - 1);
            rx_grp = grp;
            rx_data = 8'(fbyte(i, seed));
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_sof = 1'b0;
        rx_eof = 1'b0;
        rx_grp = 1'b0;
        repeat (80) @(negedge clk);
        rx_stopped = 1'b0;

        idx = cur * 256;
        bn = bnd * 256;
        ring = (RING_HI - RING_LO) * 256;
        room = (idx < bn) ? (bn - idx) : (ring - (idx - bn));
        accept = !stopped && (room >= 1518);
        if (!accept) begin
            if (stopped) begin
                check(rec_n == 0, "R1 writes on stopped frame", rec_n, 0);
                check(done_cnt == 0, "R1 pulse on stopped frame", done_cnt, 0);
            end else begin
                check(rec_n == 0, "R2 writes on frame without room", rec_n, 0);
                check(done_cnt == 0, "R10 pulse on dropped frame", done_cnt, 0);
            end
            return;
        end
        plen = (n < 60) ? 60 : n;
        slen = plen + 4;
        base = idx;
        nxt = base + ((slen + 4 + 255) / 256) * 256;
        if (nxt >= RING_HI * 256) nxt = nxt - ring;
        check(rec_n == plen + 4, "R9 write count", rec_n, plen + 4);
        if (rec_n != plen + 4) return;
        wrong = 0;
        for (int k = 0; k < plen; k++) begin
            a = base + 4 + k;
            if (a >= RING_HI * 256) a = a - ring;
            d = (k < n) ? fbyte(k, seed) : 0;
            if (rec_addr[k] != a || rec_data[k] != d) wrong = wrong + 1;
        end
        if (n < 60) check(wrong == 0, "R4 padded data placement", wrong, 0);
        else check(wrong == 0, "R3 data placement and wrap", wrong, 0);
        check(rec_addr[plen] == base && rec_data[plen] == (grp ? 'h21 : 'h01),
              "R5 header status byte", rec_data[plen], grp ? 'h21 : 'h01);
        check(rec_addr[plen+1] == base + 1 && rec_data[plen+1] == nxt / 256,
              "R5 header next page byte", rec_data[plen+1], nxt / 256);
        check(rec_addr[plen+2] == base + 2 && rec_data[plen+2] == (slen & 255),
              "R5 header length low", rec_data[plen+2], slen & 255);
        check(rec_addr[plen+3] == base + 3 && rec_data[plen+3] == (slen >> 8),
              "R5 header length high", rec_data[plen+3], slen >> 8);
        check(last_pg == nxt / 256, "R6 next page", last_pg, nxt / 256);
        check(last_stat == (grp ? 'h21 : 'h01), "R7 status byte", last_stat, grp ? 'h21 : 'h01);
        check(done_cnt == 1 && done_at == plen + 4, "R8 single pulse with last header",
              done_cnt * 1000 + done_at, 1000 + plen + 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lens [9] = '{1, 2, 59, 60, 61, 100, 252, 253, 300};
        repeat (3) @(negedge clk);
        check(mem_we == 1'b0, "R9 reset write strobe", int'(mem_we), 0);
        check(rx_done == 1'b0, "R8 reset pulse", int'(rx_done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int j = 0; j < 9; j++) run_frame(lens[j], j[0], 'h41, 'h41, 1'b0, j * 13);
        for (int j = 0; j < 9; j++) run_frame(lens[j], ~j[0], 'h4B, 'h4B, 1'b0, j * 5 + 1);
        for (int j = 0; j < 9; j++) run_frame(lens[j], j[0], 'h46, 'h46, 1'b0, j + 77);

        for (int b = RING_LO; b < RING_HI; b++) begin
            run_frame(10, b[0], 'h41, b, 1'b0, b);
            run_frame(10, b[1], 'h4B, b, 1'b0, b + 3);
        end

        run_frame(70, 1'b0, 'h44, 'h44, 1'b1, 9);
        run_frame(70, 1'b1, 'h44, 'h44, 1'b0, 9);
        run_frame(1, 1'b0, 'h44, 'h44, 1'b1, 2);
        run_frame(40, 1'b0, 'h44, 'h45, 1'b0, 4);
        run_frame(40, 1'b0, 'h44, 'h44, 1'b0, 4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule